// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

The block turns one data word into an asynchronous serial frame on a single output line. A word and its frame settings are offered with a valid/ready handshake. They are captured in the cycle of acceptance. The block then drives a start bit, 5 to 9 data bits, an optional parity bit and a stop period, and returns the line to its idle level. Every bit lasts `cfg_cpb_i` clock cycles.

The frame settings are chosen per word:
- the data bit order;
- the parity type: none, odd, even, space or mark;
- a stop period of one half, one, one and a half or two bit times;
- two independent inversions. One inverts the whole line. The other inverts only the data and parity bits.

The output line is a register, so it cannot glitch. A data-bit count below 5 is treated as 5, and a count above 9 is treated as 9. The value of `cfg_cpb_i` must be at least 2.

Top module: `uart_frame_tx`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first word arrives, `tx_o` is 1, `busy_o` is 0 and `in_ready_o` is 1.
- R2: A word is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both 1. `in_ready_o` is 1 only while `busy_o` is 0. `busy_o` is 1 from that edge until the stop period ends. An `in_valid_i` or `in_data_i` change while `busy_o` is 1 has no effect on the frame being sent.
- R3: The start bit begins on the acceptance edge. It lasts exactly `cfg_cpb_i` cycles at level 0 (before inversion).
- R4: Next come `cfg_nbits_i` data bits (5 to 9), each lasting `cfg_cpb_i` cycles. Only the low `cfg_nbits_i` bits of `in_data_i` are sent.
- R5: With `cfg_msb_first_i` = 0, bit 0 of the word is sent first. With `cfg_msb_first_i` = 1, bit `cfg_nbits_i`-1 is sent first.
- R6: `cfg_parity_i` selects the parity: 0 none, 1 odd, 2 even, 3 space (0), 4 mark (1). For odd and even, the ones in the data bits plus the parity bit make an odd or even count. When present, the parity bit lasts `cfg_cpb_i` cycles.
- R7: `cfg_stop_i` selects the stop period: 0 is `cfg_cpb_i`>>1 cycles, 1 is `cfg_cpb_i`, 2 is `cfg_cpb_i`+(`cfg_cpb_i`>>1), and 3 is 2*`cfg_cpb_i`. The line is 1 (before inversion) throughout the stop period.
- R8: With `cfg_inv_line_i` = 1, every level is complemented: idle, start, data, parity and stop.
- R9: With `cfg_inv_payload_i` = 1, only the data and parity bits are complemented. The start and stop levels are unchanged.
- R10: On the cycle after the stop period ends, `busy_o` is 0, `in_ready_o` is 1 and `tx_o` is at the idle level. A word held valid then is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Word offered |
| in_ready_o | output | 1 | Transmitter idle, ready to accept a word |
| in_data_i | input | MAX_BITS | Data word |
| cfg_nbits_i | input | $clog2(MAX_BITS+1) | Data bit count, 5 to 9 |
| cfg_msb_first_i | input | 1 | 1 = most significant data bit first |
| cfg_parity_i | input | 3 | Parity type, encoded as in R6 |
| cfg_stop_i | input | 2 | Stop period, encoded as in R7 |
| cfg_inv_line_i | input | 1 | Complement the whole line |
| cfg_inv_payload_i | input | 1 | Complement only the data and parity bits |
| cfg_cpb_i | input | CPB_W | Clock cycles per bit, at least 2 |
| tx_o | output | 1 | Serial output line |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong bit counter, or a timer that loads the wrong value, shows at `tx_o` as a segment that is one or more cycles too short or too long. That error appears within one bit period of the faulty segment. Every later segment of the same frame is also shifted, along with the return of `in_ready_o`. A wrong shift-register or parity state shows as a wrong level inside a data or parity bit of the frame being sent. A latch error in the inversion or order settings corrupts every payload bit of that frame. The bench therefore compares `tx_o` against the expected level on every cycle of every frame, across all setting combinations. It also checks the busy and ready levels on the first idle cycle after each frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_SPACE = 3'd3,
    PAR_MARK  = 3'd4
  } par_mode_e;

  typedef enum logic [1:0] {
    STOP_HALF     = 2'd0,
    STOP_ONE      = 2'd1,
    STOP_ONE_HALF = 2'd2,
    STOP_TWO      = 2'd3
  } stop_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_order.sv
module uart_tx_order #(
  parameter int W        = 9,
  parameter int MIN_BITS = 5,
  localparam int CW      = $clog2(W + 1),
  localparam int IW      = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] nbits_i,
  input  logic          msb_first_i,
  output logic [W-1:0]  word_o,
  output logic [CW-1:0] nbits_o
);
  always_comb begin
    if (nbits_i < CW'(MIN_BITS))  nbits_o = CW'(MIN_BITS);
    else if (nbits_i > CW'(W))    nbits_o = CW'(W);
    else                          nbits_o = nbits_i;
  end

  // word_o bit 0 is always the first bit on the line
  always_comb begin
    word_o = '0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(nbits_o))
        word_o[i] = msb_first_i ? data_i[IW'(int'(nbits_o) - 1 - i)] : data_i[i];
    end
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int W = 9
) (
  input  logic [W-1:0] word_i,
  input  logic [2:0]   mode_i,
  output logic         bit_o,
  output logic         en_o
);
  import uart_tx_pkg::*;

  always_comb begin
    en_o  = 1'b1;
    bit_o = 1'b0;
    case (par_mode_e'(mode_i))
      PAR_ODD:   bit_o = ~^word_i;
      PAR_EVEN:  bit_o = ^word_i;
      PAR_SPACE: bit_o = 1'b0;
      PAR_MARK:  bit_o = 1'b1;
      default:   en_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int MAX_BITS = 9,
  parameter int MIN_BITS = 5,
  parameter int CPB_W    = 16,
  localparam int CW      = $clog2(MAX_BITS + 1),
  localparam int TW      = CPB_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [MAX_BITS-1:0] in_data_i,
  input  logic [CW-1:0]       cfg_nbits_i,
  input  logic                cfg_msb_first_i,
  input  logic [2:0]          cfg_parity_i,
  input  logic [1:0]          cfg_stop_i,
  input  logic                cfg_inv_line_i,
  input  logic                cfg_inv_payload_i,
  input  logic [CPB_W-1:0]    cfg_cpb_i,
  output logic                tx_o,
  output logic                busy_o
);
  import uart_tx_pkg::*;

  tx_state_e           state_q;
  logic [MAX_BITS-1:0] shreg_q, word_d;
  logic [CW-1:0]       nbits_q, left_q, nbits_d;
  logic                par_q, par_en_q, par_d, par_en_d;
  logic [1:0]          stop_q;
  logic                il_q, ip_q, tx_q;
  logic [CPB_W-1:0]    cpb_q;
  logic                accept, bit_done, go_stop, t_load;
  logic [TW-1:0]       t_val, half_len, stop_len;

  uart_tx_order #(.W(MAX_BITS), .MIN_BITS(MIN_BITS)) u_order (
    .data_i(in_data_i), .nbits_i(cfg_nbits_i), .msb_first_i(cfg_msb_first_i),
    .word_o(word_d), .nbits_o(nbits_d)
  );

  uart_tx_parity #(.W(MAX_BITS)) u_par (
    .word_i(word_d), .mode_i(cfg_parity_i), .bit_o(par_d), .en_o(par_en_d)
  );

  assign accept   = in_valid_i && (state_q == ST_IDLE);
  assign half_len = TW'(cpb_q) >> 1;

  always_comb begin
    case (stop_mode_e'(stop_q))
      STOP_HALF:     stop_len = half_len;
      STOP_ONE:      stop_len = TW'(cpb_q);
      STOP_ONE_HALF: stop_len = TW'(cpb_q) + half_len;
      default:       stop_len = TW'(cpb_q) << 1;
    endcase
  end

  assign go_stop = bit_done && ((state_q == ST_PAR) ||
                   (state_q == ST_DATA && left_q == '0 && !par_en_q));
  assign t_load  = accept || (bit_done && (state_q == ST_START ||
                   state_q == ST_DATA || state_q == ST_PAR));
  assign t_val   = accept  ? TW'(cfg_cpb_i) - 1'b1 :
                   go_stop ? stop_len - 1'b1 : TW'(cpb_q) - 1'b1;

  uart_tx_timer #(.W(TW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(t_load), .val_i(t_val), .done_o(bit_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      nbits_q  <= '0;
      left_q   <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
      stop_q   <= '0;
      il_q     <= 1'b0;
      ip_q     <= 1'b0;
      cpb_q    <= '0;
      tx_q     <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          tx_q <= ~cfg_inv_line_i;
          if (accept) begin
            state_q  <= ST_START;
            shreg_q  <= word_d;
            nbits_q  <= nbits_d;
            par_q    <= par_d;
            par_en_q <= par_en_d;
            stop_q   <= cfg_stop_i;
            il_q     <= cfg_inv_line_i;
            ip_q     <= cfg_inv_payload_i;
            cpb_q    <= cfg_cpb_i;
            tx_q     <= cfg_inv_line_i;
          end
        end
        ST_START: if (bit_done) begin
          state_q <= ST_DATA;
          left_q  <= nbits_q - 1'b1;
          tx_q    <= shreg_q[0] ^ ip_q ^ il_q;
        end
        ST_DATA: if (bit_done) begin
          if (left_q != '0) begin
            left_q  <= left_q - 1'b1;
            shreg_q <= shreg_q >> 1;
            tx_q    <= shreg_q[1] ^ ip_q ^ il_q;
          end else if (par_en_q) begin
            state_q <= ST_PAR;
            tx_q    <= par_q ^ ip_q ^ il_q;
          end else begin
            state_q <= ST_STOP;
            tx_q    <= ~il_q;
          end
        end
        ST_PAR: if (bit_done) begin
          state_q <= ST_STOP;
          tx_q    <= ~il_q;
        end
        ST_STOP: if (bit_done) begin
          state_q <= ST_IDLE;
          tx_q    <= ~il_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_o       = tx_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign in_ready_o = (state_q == ST_IDLE);

  // R2
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !busy_o);
  // R2
  accept_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(in_valid_i));
  // R3
  start_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (tx_o == il_q));
  // R7
  stop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (tx_o == !il_q));
  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !bit_done) |=> (state_q == ST_DATA && $stable(tx_o)));
  // R10
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (tx_o == !il_q));
endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, tx, busy;
  logic [MAXB-1:0] in_data = '0;
  logic [3:0] nbits = 4'd8;
  logic msb = 1'b0, inv_l = 1'b0, inv_p = 1'b0;
  logic [2:0] par = '0;
  logic [1:0] stp = 2'd1;
  logic [15:0] cpb = 16'd5;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .cfg_nbits_i(nbits), .cfg_msb_first_i(msb),
    .cfg_parity_i(par), .cfg_stop_i(stp), .cfg_inv_line_i(inv_l),
    .cfg_inv_payload_i(inv_p), .cfg_cpb_i(cpb), .tx_o(tx), .busy_o(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Check one segment: level lvl for len cycles, busy high and ready low throughout
  task automatic seg(input logic lvl, input int len, input string tag);
    int bad = 0, hs = 0;
    for (int c = 0; c < len; c++) begin
      if (tx !== lvl) bad++;
      if (busy !== 1'b1 || in_ready !== 1'b0) hs++;
      @(negedge clk);
    end
    check(bad == 0, tag, bad, 0);
    check(hs == 0, "R2 busy/ready during frame", hs, 0);
  endtask

  task automatic frame(input logic [MAXB-1:0] d, input int nb, input bit m, input int pm,
                       input int sm, input bit il, input bit ip, input bit noise, input int cp);
    logic [MAXB-1:0] msk;
    int ones, pbit, slen;
    logic b;
    msk  = MAXB'((1 << nb) - 1);
    ones = $countones(d & msk);
    case (pm)
      1: pbit = (ones % 2 == 0) ? 1 : 0;
      2: pbit = ones % 2;
      3: pbit = 0;
      default: pbit = 1;
    endcase
    case (sm)
      0: slen = cp / 2;
      1: slen = cp;
      2: slen = cp + cp / 2;
      default: slen = 2 * cp;
    endcase
    in_data = d; nbits = 4'(nb); msb = m; par = 3'(pm); stp = 2'(sm);
    inv_l = il; inv_p = ip; cpb = 16'(cp); in_valid = 1'b1;
    check(in_ready === 1'b1, "R2 ready before accept", int'(in_ready), 1);
    @(negedge clk);
    in_valid = noise;
    if (noise) in_data = ~d;
    seg(il, cp, "R3 start bit");
    for (int i = 0; i < nb; i++) begin
      b = m ? d[nb-1-i] : d[i];
      seg(b ^ ip ^ il, cp, (il || ip) ? "R4 R5 R8 R9 data bit" : "R4 R5 data bit");
    end
    if (pm != 0) seg(1'(pbit) ^ ip ^ il, cp, (il || ip) ? "R6 R8 R9 parity" : "R6 parity");
    in_valid = 1'b0;
    seg(~il, slen, il ? "R7 R8 stop" : "R7 R9 stop");
    check(busy === 1'b0 && in_ready === 1'b1, "R10 idle after stop", int'(busy), 0);
    check(tx === ~il, "R10 R8 idle level", int'(tx), int'(~il));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx === 1'b1, "R1 reset line", int'(tx), 1);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    check(in_ready === 1'b1, "R1 reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx === 1'b1 && busy === 1'b0, "R1 idle after reset", int'(tx), 1);
    for (int nb = 5; nb <= 9; nb++)
      for (int pm = 0; pm <= 4; pm++)
        for (int sm = 0; sm <= 3; sm++)
          for (int md = 0; md < 8; md++)
            frame(MAXB'((nb * 37 + pm * 11 + sm * 5 + md * 3) ^ 9'h155), nb, md[0],
                  pm, sm, md[1], md[2], ((pm + sm) % 2) == 1, 5);
    for (int sm = 0; sm <= 3; sm++) begin
      frame(9'h0A5, 8, 1'b0, 1, sm, 1'b0, 1'b0, 1'b1, 2);
      frame(9'h1C3, 9, 1'b1, 2, sm, 1'b1, 1'b0, 1'b0, 4);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule